// File: doc/BRIEF.md
# Single-Segment SD Data Mover

This block moves one contiguous, 8-byte-aligned buffer between system memory and the data FIFO of an SD host. Software writes a mode word (transfer direction, element width, fixed or incrementing address), a start address split over a low and a high 32-bit word, a block count, and then a start command. The engine issues one memory beat per element, counts bytes until the programmed length is reached, and pulses a completion output after the final beat has been acknowledged. The host uses that pulse as its data-end event.

Each direction has its own active-low soft-reset bit. Clearing the bit of the running direction abandons the transfer at once. Start requests that cannot be honoured (a misaligned address, an undefined direction code, a zero block count) set an error flag and never reach the memory bus.

Top module: `sdma_engine`

## Requirements
- R1: While reset is held and right after it, `busy`, `done`, `err`, `mem_req`, `fifo_rd_en` and `fifo_wr_en` are all 0.
- R2: The mode word field [17:16] selects the direction. Code 0 reads memory (`mem_we`=0) and pushes each returned word into the card FIFO through `fifo_wr_en`/`fifo_wr_data`. Code 1 pops the FIFO through `fifo_rd_en` and writes that word to memory (`mem_we`=1).
- R3: The mode word field [5:4] selects the element size: 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. `mem_size` carries that code on every beat, and a transfer takes total bytes divided by element bytes beats.
- R4: Mode word bit 0 set makes the address advance by the element size after each acknowledged beat. Bit 0 clear keeps every beat at the start address.
- R5: Writing register index 1 with bit 0 set while idle starts exactly one transfer. The command does not persist, so no further transfer follows without a new write, and a start written while busy is ignored.
- R6: Register index 2 holds address bits [31:0] and index 3 holds the bits above 31. The first beat goes to the address the two words form.
- R7: A start with address bits [2:0] not zero, with direction code 2 or 3, or with a block count of 0 sets `err` and makes no memory request. `err` stays set until a start is accepted.
- R8: `done` is a one-cycle pulse in the cycle after the last beat's `mem_ack`, and it never occurs without an accepted start.
- R9: In direction 0 no new memory read is issued while `fifo_wr_full` is high. In direction 1 the FIFO is not popped while `fifo_rd_empty` is high.
- R10: Register index 4 bit 8 is the active-low soft reset of direction 0 and bit 9 that of direction 1 (both 1 after reset). Clearing the running direction's bit ends the transfer with no `done`, and a start for a direction whose bit is 0 is ignored.
- R11: Register index 5 holds a 16-bit block count, and a transfer moves block count times `BLK_BYTES` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory beat request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_size | output | 2 | Element size code of the beat |
| mem_addr | output | ADDR_W | Beat address |
| mem_wdata | output | 64 | Write data for memory |
| mem_ack | input | 1 | Beat completes in this cycle |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| fifo_wr_full | input | 1 | Card-bound FIFO cannot accept data |
| fifo_wr_en | output | 1 | Push into the card-bound FIFO |
| fifo_wr_data | output | 64 | Word pushed into the card-bound FIFO |
| fifo_rd_empty | input | 1 | Card-sourced FIFO holds no data |
| fifo_rd_en | output | 1 | Pop from the card-sourced FIFO |
| fifo_rd_data | input | 64 | Head word of the card-sourced FIFO |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Last start request was rejected |

## Verification
The hardest cases to reach from the ports are a soft reset that lands in the middle of a transfer and a stall that lasts until the FIFO side releases it. To reach the first, the stimulus starts a long byte-wide transfer and clears the channel bit after a fixed number of cycles, while the memory model still has beats outstanding. It then issues a start to the held channel, which must be ignored. For the stalls, the FIFO model's producer and consumer are switched off until the FIFO is full or empty, and switched on again later. A behavioural model checks every cycle that no request or pop slips out while the engine is stalled.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
   localparam int DATA_W  = 64;
   localparam int ALIGN_W = 3;

   // register indices seen on cfg_idx
   localparam logic [2:0] IDX_MODE    = 3'd0;
   localparam logic [2:0] IDX_CTRL    = 3'd1;
   localparam logic [2:0] IDX_ADDR_LO = 3'd2;
   localparam logic [2:0] IDX_ADDR_HI = 3'd3;
   localparam logic [2:0] IDX_CHRST   = 3'd4;
   localparam logic [2:0] IDX_BLOCKS  = 3'd5;

   // field positions inside the written words
   localparam int MODE_INC_BIT = 0;
   localparam int MODE_WID_LSB = 4;
   localparam int MODE_DIR_LSB = 16;
   localparam int CTRL_GO_BIT  = 0;
   localparam int CHRST_LSB    = 8;

   typedef struct packed {
      logic [1:0] dir;
      logic [1:0] wid;
      logic       inc;
   } mode_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_BUS  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/sdma_cfg_regs.sv
module sdma_cfg_regs
   import sdma_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int BLKCNT_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [2:0]          cfg_idx,
   input  logic [31:0]         cfg_wdata,
   output mode_t               mode,
   output logic [ADDR_W-1:0]   start_addr,
   output logic [BLKCNT_W-1:0] blocks,
   output logic [1:0]          chan_rst_n,
   output logic                go
);
   logic [31:0] addr_lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode       <= '0;
         addr_lo_q  <= '0;
         blocks     <= '0;
         chan_rst_n <= 2'b11;
      end else if (cfg_we) begin
         unique case (cfg_idx)
            IDX_MODE: begin
               mode.dir <= cfg_wdata[MODE_DIR_LSB +: 2];
               mode.wid <= cfg_wdata[MODE_WID_LSB +: 2];
               mode.inc <= cfg_wdata[MODE_INC_BIT];
            end
            IDX_ADDR_LO: addr_lo_q  <= cfg_wdata;
            IDX_CHRST:   chan_rst_n <= cfg_wdata[CHRST_LSB +: 2];
            IDX_BLOCKS:  blocks     <= cfg_wdata[BLKCNT_W-1:0];
            default: ;
         endcase
      end
   end

   // the high word exists only when the address is wider than 32 bits
   generate
      if (ADDR_W > 32) begin : g_hi
         logic [ADDR_W-33:0] addr_hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               addr_hi_q <= '0;
            else if (cfg_we && cfg_idx == IDX_ADDR_HI)
               addr_hi_q <= cfg_wdata[ADDR_W-33:0];
         end
         assign start_addr = {addr_hi_q, addr_lo_q};
      end else begin : g_lo_only
         assign start_addr = addr_lo_q[ADDR_W-1:0];
      end
   endgenerate

   assign go = cfg_we && (cfg_idx == IDX_CTRL) && cfg_wdata[CTRL_GO_BIT];

   logic spare_unused;
   assign spare_unused = ^{cfg_wdata[31:18], cfg_wdata[15:10], cfg_wdata[7:6], cfg_wdata[3:1]};
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
   import sdma_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int BLKCNT_W  = 16,
   parameter int BLK_SHIFT = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  mode_t               mode,
   input  logic [ADDR_W-1:0]   start_addr,
   input  logic [BLKCNT_W-1:0] blocks,
   input  logic [1:0]          chan_rst_n,
   output logic                mem_req,
   output logic                mem_we,
   output logic [1:0]          mem_size,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic                mem_ack,
   input  logic                fifo_wr_full,
   output logic                fifo_wr_en,
   input  logic                fifo_rd_empty,
   output logic                fifo_rd_en,
   input  logic [DATA_W-1:0]   fifo_rd_data,
   output logic                busy,
   output logic                done,
   output logic                err
);
   localparam int CNT_W = BLKCNT_W + BLK_SHIFT;

   seq_state_e        st_q;
   logic              dir_q, inc_q;
   logic [1:0]        wid_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  left_q;
   logic [DATA_W-1:0] wdata_q;
   logic              done_q, err_q;

   logic              chan_ok, flow_ok, last_beat, start_bad;
   logic [CNT_W-1:0]  step_bytes, total_bytes;
   logic [ADDR_W-1:0] step_addr;

   always_comb begin
      chan_ok     = chan_rst_n[dir_q];
      flow_ok     = dir_q ? !fifo_rd_empty : !fifo_wr_full;
      step_bytes  = CNT_W'(1) << wid_q;
      step_addr   = ADDR_W'(1) << wid_q;
      total_bytes = CNT_W'(blocks) << BLK_SHIFT;
      last_beat   = (left_q == step_bytes);
      start_bad   = (start_addr[ALIGN_W-1:0] != '0) || mode.dir[1] || (blocks == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         dir_q   <= 1'b0;
         inc_q   <= 1'b0;
         wid_q   <= '0;
         addr_q  <= '0;
         left_q  <= '0;
         wdata_q <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (go) begin
                  if (start_bad) begin
                     err_q <= 1'b1;
                  end else if (chan_rst_n[mode.dir[0]]) begin
                     err_q  <= 1'b0;
                     dir_q  <= mode.dir[0];
                     wid_q  <= mode.wid;
                     inc_q  <= mode.inc;
                     addr_q <= start_addr;
                     left_q <= total_bytes;
                     st_q   <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: begin
               if (!chan_ok) begin
                  st_q <= ST_IDLE;
               end else if (flow_ok) begin
                  if (dir_q) wdata_q <= fifo_rd_data;
                  st_q <= ST_BUS;
               end
            end
            ST_BUS: begin
               if (!chan_ok) begin
                  st_q <= ST_IDLE;
               end else if (mem_ack) begin
                  left_q <= left_q - step_bytes;
                  if (inc_q) addr_q <= addr_q + step_addr;
                  if (last_beat) begin
                     done_q <= 1'b1;
                     st_q   <= ST_IDLE;
                  end else begin
                     st_q <= ST_WAIT;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req    = (st_q == ST_BUS);
   assign mem_we     = dir_q;
   assign mem_size   = wid_q;
   assign mem_addr   = addr_q;
   assign mem_wdata  = wdata_q;
   assign fifo_rd_en = (st_q == ST_WAIT) && dir_q && chan_ok && !fifo_rd_empty;
   assign fifo_wr_en = (st_q == ST_BUS) && !dir_q && chan_ok && mem_ack;
   assign busy       = (st_q != ST_IDLE);
   assign done       = done_q;
   assign err        = err_q;
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
   import sdma_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int BLK_BYTES = 512,
   parameter int BLKCNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_idx,
   input  logic [31:0]       cfg_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [1:0]        mem_size,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [63:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [63:0]       mem_rdata,
   input  logic              fifo_wr_full,
   output logic              fifo_wr_en,
   output logic [63:0]       fifo_wr_data,
   input  logic              fifo_rd_empty,
   output logic              fifo_rd_en,
   input  logic [63:0]       fifo_rd_data,
   output logic              busy,
   output logic              done,
   output logic              err
);
   localparam int BLK_SHIFT = $clog2(BLK_BYTES);

   generate
      if (ADDR_W < 32 || ADDR_W > 64) begin : g_bad_addr
         $error("sdma_engine: ADDR_W must lie in 32..64");
      end
      if (BLK_BYTES < 8 || (1 << BLK_SHIFT) != BLK_BYTES) begin : g_bad_blk
         $error("sdma_engine: BLK_BYTES must be a power of two of at least 8");
      end
      if (BLKCNT_W < 1 || BLKCNT_W > 32) begin : g_bad_cnt
         $error("sdma_engine: BLKCNT_W must lie in 1..32");
      end
   endgenerate

   mode_t               mode;
   logic [ADDR_W-1:0]   start_addr;
   logic [BLKCNT_W-1:0] blocks;
   logic [1:0]          chan_rst_n;
   logic                go;

   sdma_cfg_regs #(.ADDR_W(ADDR_W), .BLKCNT_W(BLKCNT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_idx    (cfg_idx),
      .cfg_wdata  (cfg_wdata),
      .mode       (mode),
      .start_addr (start_addr),
      .blocks     (blocks),
      .chan_rst_n (chan_rst_n),
      .go         (go)
   );

   sdma_seq #(.ADDR_W(ADDR_W), .BLKCNT_W(BLKCNT_W), .BLK_SHIFT(BLK_SHIFT)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .go            (go),
      .mode          (mode),
      .start_addr    (start_addr),
      .blocks        (blocks),
      .chan_rst_n    (chan_rst_n),
      .mem_req       (mem_req),
      .mem_we        (mem_we),
      .mem_size      (mem_size),
      .mem_addr      (mem_addr),
      .mem_wdata     (mem_wdata),
      .mem_ack       (mem_ack),
      .fifo_wr_full  (fifo_wr_full),
      .fifo_wr_en    (fifo_wr_en),
      .fifo_rd_empty (fifo_rd_empty),
      .fifo_rd_en    (fifo_rd_en),
      .fifo_rd_data  (fifo_rd_data),
      .busy          (busy),
      .done          (done),
      .err           (err)
   );

   assign fifo_wr_data = mem_rdata;
endmodule

// File: rtl/sdma_chk.sv
module sdma_chk #(
   parameter int ADDR_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [1:0]        mem_size,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              fifo_wr_full,
   input logic              fifo_wr_en,
   input logic              fifo_rd_empty,
   input logic              fifo_rd_en,
   input logic              busy,
   input logic              done,
   input logic              err
);
   // R8: completion only follows an acknowledged beat
   a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_req && mem_ack));

   // R8: the engine is idle while it reports completion
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R7: a rejected start leaves the engine idle
   a_r7_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> !busy && !mem_req);

   // R9: a new read toward the card FIFO needs room there
   a_r9_read_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) && !mem_we |-> $past(!fifo_wr_full));

   // R9: no pop from an empty FIFO
   a_r9_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd_en |-> !fifo_rd_empty);

   // R2: pushes happen only on acknowledged reads
   a_r2_push_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr_en |-> mem_req && mem_ack && !mem_we);

   // R2: pops and pushes never coincide
   a_r2_one_side: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fifo_rd_en, fifo_wr_en}));

   // R3: the element size holds for the whole transfer
   a_r3_size_stable: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(mem_size));

   // R7: an accepted transfer starts on an 8-byte boundary
   a_r7_aligned_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> mem_addr[2:0] == 3'd0);

   // R1: no bus activity while idle
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req && !fifo_rd_en);
endmodule

bind sdma_engine sdma_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mem_req       (mem_req),
   .mem_we        (mem_we),
   .mem_ack       (mem_ack),
   .mem_size      (mem_size),
   .mem_addr      (mem_addr),
   .fifo_wr_full  (fifo_wr_full),
   .fifo_wr_en    (fifo_wr_en),
   .fifo_rd_empty (fifo_rd_empty),
   .fifo_rd_en    (fifo_rd_en),
   .busy          (busy),
   .done          (done),
   .err           (err)
);

// File: tb/sdma_engine_test.sv
module sdma_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int BLK        = 32;
   localparam int FDEPTH     = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic        mem_req, mem_we;
   logic [1:0]  mem_size;
   logic [63:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        fifo_wr_full = 1'b0;
   logic        fifo_wr_en;
   logic [63:0] fifo_wr_data;
   logic        fifo_rd_empty = 1'b1;
   logic        fifo_rd_en;
   logic [63:0] fifo_rd_data = '0;
   logic        busy, done, err;

   sdma_engine #(.ADDR_W(64), .BLK_BYTES(BLK), .BLKCNT_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .fifo_wr_full(fifo_wr_full), .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
      .fifo_rd_empty(fifo_rd_empty), .fifo_rd_en(fifo_rd_en), .fifo_rd_data(fifo_rd_data),
      .busy(busy), .done(done), .err(err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] mem_word(input logic [63:0] a);
      return {~a[31:0], a[31:0]};
   endfunction

   // environment
   logic [63:0] fq[$];
   logic [63:0] pop_log[$];
   logic [63:0] wr_data_log[$];
   logic [63:0] wr_addr_log[$];
   bit  prod_on = 0, cons_on = 0, started = 0;
   int  prod_val = 'h500;
   int  hold = 0, mem_lat = 0, beat_cnt = 0, done_cnt = 0, m_done_cnt = 0;

   // reference model
   bit          m_busy, m_bus, m_done, m_err, m_dir, m_inc;
   int          m_wid, m_left;
   logic [63:0] m_addr, m_wdata;
   int          r_dir, r_wid, r_blocks;
   bit          r_inc;
   logic [31:0] r_lo, r_hi;
   logic [1:0]  r_rst;

   always @(posedge clk) begin
      started <= 1'b1;
      if (rst_n) begin
         if (fifo_rd_en) void'(fq.pop_front());
         if (cons_on && fq.size() > 0) pop_log.push_back(fq.pop_front());
         if (fifo_wr_en) fq.push_back(fifo_wr_data);
         if (prod_on && fq.size() < FDEPTH) begin
            fq.push_back(64'(prod_val));
            prod_val++;
         end
         if (mem_req && mem_ack) begin
            beat_cnt++;
            if (mem_we) begin
               wr_data_log.push_back(mem_wdata);
               wr_addr_log.push_back(mem_addr);
            end
            hold = 0;
         end else if (mem_req) hold++;
         else hold = 0;
         if (done) done_cnt++;
      end
      // model step
      m_done = 0;
      if (!rst_n) begin
         m_busy = 0; m_bus = 0; m_err = 0; m_dir = 0; m_inc = 0; m_wid = 0; m_left = 0;
         m_addr = '0; m_wdata = '0;
         r_dir = 0; r_wid = 0; r_inc = 0; r_blocks = 0; r_lo = '0; r_hi = '0; r_rst = 2'b11;
      end else begin
         if (m_busy) begin
            if (!r_rst[m_dir]) begin
               m_busy = 0; m_bus = 0;
            end else if (!m_bus) begin
               if (m_dir ? !fifo_rd_empty : !fifo_wr_full) begin
                  m_bus = 1;
                  if (m_dir) m_wdata = fifo_rd_data;
               end
            end else if (mem_ack) begin
               m_left--;
               if (m_inc) m_addr = m_addr + 64'(1 << m_wid);
               m_bus = 0;
               if (m_left == 0) begin
                  m_busy = 0; m_done = 1; m_done_cnt++;
               end
            end
         end else if (cfg_we && cfg_idx == 3'd1 && cfg_wdata[0]) begin
            if ({r_hi, r_lo} % 8 != 0 || r_dir > 1 || r_blocks == 0) m_err = 1;
            else if (r_rst[r_dir]) begin
               m_err = 0; m_busy = 1; m_bus = 0; m_dir = r_dir[0]; m_wid = r_wid;
               m_inc = r_inc; m_addr = {r_hi, r_lo}; m_left = r_blocks * BLK / (1 << r_wid);
            end
         end
         if (cfg_we) begin
            case (cfg_idx)
               3'd0: begin
                  r_dir = int'(cfg_wdata[17:16]);
                  r_wid = int'(cfg_wdata[5:4]);
                  r_inc = cfg_wdata[0];
               end
               3'd2: r_lo = cfg_wdata;
               3'd3: r_hi = cfg_wdata;
               3'd4: r_rst = cfg_wdata[9:8];
               3'd5: r_blocks = int'(cfg_wdata[15:0]);
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      fifo_wr_full  = (fq.size() >= FDEPTH);
      fifo_rd_empty = (fq.size() == 0);
      fifo_rd_data  = (fq.size() > 0) ? fq[0] : 64'd0;
      mem_ack       = mem_req && (hold >= mem_lat);
      mem_rdata     = mem_word(mem_addr);
      #1;
      if (started) begin
         bit exp_req, exp_rd, exp_wr;
         exp_req = m_busy && m_bus;
         exp_rd  = m_busy && !m_bus && m_dir && !fifo_rd_empty && r_rst[1];
         exp_wr  = exp_req && !m_dir && mem_ack && r_rst[0];
         chk(busy == m_busy, "R5", "busy", busy, m_busy);
         chk(done == m_done, "R8", "done", done, m_done);
         chk(err == m_err, "R7", "err", err, m_err);
         chk(mem_req == exp_req, "R9", "mem_req", mem_req, exp_req);
         chk(fifo_rd_en == exp_rd, "R9", "fifo_rd_en", fifo_rd_en, exp_rd);
         chk(fifo_wr_en == exp_wr, "R2", "fifo_wr_en", fifo_wr_en, exp_wr);
         if (exp_req) begin
            chk(mem_addr == m_addr, "R4", "mem_addr", mem_addr, m_addr);
            chk(mem_we == m_dir, "R2", "mem_we", mem_we, m_dir);
            chk(int'(mem_size) == m_wid, "R3", "mem_size", mem_size, m_wid);
            if (m_dir) chk(mem_wdata == m_wdata, "R2", "mem_wdata", mem_wdata, m_wdata);
         end
      end
   end

   task automatic wr(input logic [2:0] idx, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 3000) begin
         @(negedge clk);
         n++;
      end
      repeat (8) @(negedge clk);
   endtask

   task automatic flush();
      @(posedge clk);
      #1;
      fq.delete(); pop_log.delete(); wr_data_log.delete(); wr_addr_log.delete();
      beat_cnt = 0;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      int d0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !err, "R1", "status in reset", {busy, done, err}, 0);
      chk(!mem_req && !fifo_rd_en && !fifo_wr_en, "R1", "bus in reset",
          {mem_req, fifo_rd_en, fifo_wr_en}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !err && !mem_req, "R1", "idle after reset", {busy, err, mem_req}, 0);

      // R6 / R4: memory to card, 8-byte elements, incrementing, high word used
      cons_on = 1; mem_lat = 1;
      wr(3'd0, 32'h31); wr(3'd2, 32'h40); wr(3'd3, 32'h1); wr(3'd5, 32'd1);
      flush();
      wr(3'd1, 32'h1);
      wait_idle();
      chk(beat_cnt == 4, "R11", "beats dir0 w64", beat_cnt, 4);
      chk(pop_log.size() == 4, "R2", "words pushed", pop_log.size(), 4);
      if (pop_log.size() == 4) begin
         chk(pop_log[0] == mem_word(64'h1_0000_0040), "R6", "first word", pop_log[0],
             mem_word(64'h1_0000_0040));
         chk(pop_log[3] == mem_word(64'h1_0000_0058), "R4", "last word", pop_log[3],
             mem_word(64'h1_0000_0058));
      end

      // R2 / R11: card to memory, 4-byte elements, two blocks
      cons_on = 0; mem_lat = 2;
      wr(3'd0, 32'h10021); wr(3'd2, 32'h1000); wr(3'd3, 32'h0); wr(3'd5, 32'd2);
      flush();
      prod_val = 'h500; prod_on = 1;
      wr(3'd1, 32'h1);
      wait_idle();
      prod_on = 0;
      chk(wr_addr_log.size() == 16, "R11", "beats two blocks", wr_addr_log.size(), 16);
      if (wr_addr_log.size() == 16) begin
         chk(wr_data_log[0] == 64'h500, "R2", "first write data", wr_data_log[0], 64'h500);
         chk(wr_addr_log[15] == 64'h103C, "R4", "last write addr", wr_addr_log[15], 64'h103C);
      end

      // R4: fixed address, byte elements
      cons_on = 1; mem_lat = 0;
      wr(3'd0, 32'h0); wr(3'd2, 32'h2000); wr(3'd5, 32'd1);
      flush();
      wr(3'd1, 32'h1);
      wait_idle();
      chk(beat_cnt == 32, "R3", "beats byte elements", beat_cnt, 32);
      begin
         int bad = 0;
         foreach (pop_log[i]) if (pop_log[i] != mem_word(64'h2000)) bad++;
         chk(bad == 0 && pop_log.size() == 32, "R4", "fixed address words", bad, 0);
      end

      // R9: stall on full FIFO
      cons_on = 0; mem_lat = 1;
      wr(3'd0, 32'h31); wr(3'd2, 32'h3000); wr(3'd5, 32'd2);
      flush();
      wr(3'd1, 32'h1);
      repeat (20) @(negedge clk);
      chk(busy && !mem_req, "R9", "stalled on full", {busy, mem_req}, 2);
      chk(fq.size() == FDEPTH, "R9", "fifo level", fq.size(), FDEPTH);
      cons_on = 1;
      wait_idle();
      chk(beat_cnt == 8, "R9", "beats after full stall", beat_cnt, 8);

      // R9 / R3: stall on empty FIFO, 2-byte elements
      cons_on = 0;
      wr(3'd0, 32'h10011); wr(3'd2, 32'h4000); wr(3'd5, 32'd1);
      flush();
      wr(3'd1, 32'h1);
      repeat (10) @(negedge clk);
      chk(busy && !mem_req && !fifo_rd_en, "R9", "stalled on empty",
          {busy, mem_req, fifo_rd_en}, 4);
      prod_on = 1;
      wait_idle();
      prod_on = 0;
      chk(beat_cnt == 16, "R3", "beats 16-bit", beat_cnt, 16);
      if (wr_addr_log.size() > 1)
         chk(wr_addr_log[1] - wr_addr_log[0] == 2, "R3", "address step",
             wr_addr_log[1] - wr_addr_log[0], 2);

      // R7: rejected starts
      cons_on = 1;
      wr(3'd0, 32'h31); wr(3'd2, 32'h3004); wr(3'd5, 32'd1);
      flush();
      wr(3'd1, 32'h1);
      repeat (5) @(negedge clk);
      chk(err && !busy && beat_cnt == 0, "R7", "misaligned", {err, busy}, 2);
      wr(3'd2, 32'h3000); wr(3'd0, 32'h20031);
      wr(3'd1, 32'h1);
      repeat (5) @(negedge clk);
      chk(err && !busy && beat_cnt == 0, "R7", "direction code 2", {err, busy}, 2);
      wr(3'd0, 32'h31); wr(3'd5, 32'd0);
      wr(3'd1, 32'h1);
      repeat (5) @(negedge clk);
      chk(err && !busy && beat_cnt == 0, "R7", "zero blocks", {err, busy}, 2);
      wr(3'd5, 32'd1);
      wr(3'd1, 32'h1);
      wait_idle();
      chk(!err && beat_cnt == 4, "R7", "err cleared by valid start", err, 0);

      // R5: a start while busy is ignored, and the command does not persist
      flush();
      d0 = done_cnt;
      wr(3'd1, 32'h1);
      wr(3'd1, 32'h1);
      wait_idle();
      chk(beat_cnt == 4 && done_cnt == d0 + 1, "R5", "one transfer", beat_cnt, 4);
      repeat (20) @(negedge clk);
      chk(beat_cnt == 4 && !busy, "R5", "no repeat", beat_cnt, 4);

      // R10: soft reset of a running channel, then start on a held channel
      cons_on = 0; mem_lat = 1;
      wr(3'd0, 32'h10001); wr(3'd2, 32'h5000); wr(3'd5, 32'd4);
      flush();
      d0 = done_cnt;
      prod_on = 1;
      wr(3'd1, 32'h1);
      repeat (30) @(negedge clk);
      chk(busy, "R10", "running before abort", busy, 1);
      wr(3'd4, 32'h100);
      repeat (5) @(negedge clk);
      chk(!busy && !mem_req && done_cnt == d0, "R10", "aborted without done",
          {busy, mem_req}, 0);
      prod_on = 0;
      flush();
      wr(3'd5, 32'd1);
      wr(3'd1, 32'h1);
      repeat (10) @(negedge clk);
      chk(!busy && !err && beat_cnt == 0, "R10", "start on held channel", {busy, err}, 0);
      wr(3'd4, 32'h300);

      // R8: completions match accepted, finished transfers
      repeat (5) @(negedge clk);
      chk(done_cnt == 7, "R8", "done count", done_cnt, 7);
      chk(done_cnt == m_done_cnt, "R8", "done vs model", done_cnt, m_done_cnt);
      finish_run();
   end
endmodule